// File: doc/BRIEF.md
# Two-Step Ring-Oscillator Time Capture

This block is the digital back end of a per-pixel time-to-digital converter. It is built around a gated multi-phase ring oscillator whose taps arrive as digital inputs. A start event opens a measurement window and raises the oscillator enable. While the window is open, a coarse counter counts full oscillator periods as rising edges of the last tap. A stop event closes the window, which freezes the oscillator.

One cycle after the stop, the coarse count and the frozen tap states are captured together. The taps are read as a thermometer, converted to a binary sub-period value, and merged with the count into a single 16-bit word. A later rising edge on the load input copies that word into the pixel output register. The reset input clears the whole pixel, which then waits for the next start.

The fine field has FINE_W bits and the design uses 2^FINE_W - 1 taps. Each coarse step is therefore worth 2^FINE_W fine steps, and the output word reads directly as time in units of one LSB (about 156 ps).

Top module: `tdc_capture`

## Requirements
- R1: A rising edge on `start` while idle raises `osc_en` from the next clock edge. A rising edge on `stop` while the window is open drops `osc_en` at the next clock edge.
- R2: Each rising edge of `phase[NPH-1]` seen while `osc_en` is high adds one to the coarse count, and the count is cleared when a window opens. Edges seen while `osc_en` is low are not counted.
- R3: The coarse count saturates at all-ones (1023 with the default width) and does not wrap. An edge that arrives at saturation sets an overflow flag, which is reported on `code_ovf` after a load.
- R4: The fine value is the number of consecutive ones in `phase` counted upward from bit 0, ending at the first one-to-zero transition. A one above the first zero (a bubble) is ignored.
- R5: The measurement word is coarse count × 2^FINE_W + fine value. Bits 15..6 hold the coarse count and bits 5..0 hold the fine value. It is captured one cycle after the stop edge, using the tap states present in that cycle.
- R6: A rising edge on `load` copies the last captured word and its overflow flag to `code` and `code_ovf`. Without such an edge, both outputs hold their value.
- R7: While `rst` is high, `osc_en`, `code` and `code_ovf` are cleared, and the pixel returns to idle.
- R8: A stop edge while idle, or a second stop edge after the window has closed, changes neither the captured word nor `osc_en`.
- R9: A start edge while the window is open is ignored: it does not clear the count and does not restart the window.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst | input | 1 | Synchronous active-high pixel clear |
| start | input | 1 | Window-open request; rising edge acts |
| stop | input | 1 | Window-close request; rising edge acts |
| load | input | 1 | Output latch request; rising edge acts |
| phase | input | NPH (63) | Oscillator tap states; bit NPH-1 is the last stage |
| osc_en | output | 1 | Oscillator run enable, high inside the window |
| code | output | 16 | Latched measurement word |
| code_ovf | output | 1 | Latched coarse overflow flag |

## Verification
The bench builds the block with the default parameters: a 16-bit word with a 6-bit fine field, 63 taps and a 10-bit coarse counter. With these values, the saturation point of 1023 periods is reached in about two thousand clock cycles. The bench tests exactly 1023 and 1024 edges to probe the boundary. The 63-tap thermometer is wide enough to test a zero fine code, codes near the top of the field, and a bubble placed above the first zero.

// File: rtl/tdc_pkg.sv
package tdc_pkg;

    typedef enum logic [1:0] {
        W_IDLE   = 2'd0,
        W_RUN    = 2'd1,
        W_SETTLE = 2'd2
    } win_st_e;

    // Length of the leading run of ones from bit 0 (bubbles above are dropped)
    function automatic int unsigned lead_ones(input logic [254:0] v, input int unsigned n);
        int unsigned k;
        logic        run;
        k   = 0;
        run = 1'b1;
        for (int unsigned i = 0; i < 255; i++) begin
            if (i < n) begin
                if (run && v[i]) k = k + 1;
                else             run = 1'b0;
            end
        end
        return k;
    endfunction

endpackage

// File: rtl/tdc_window.sv
module tdc_window
    import tdc_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic start,
    input  logic stop,
    output logic osc_en,
    output logic accept,
    output logic capture
);
    win_st_e st;
    logic    start_d, stop_d;
    logic    start_e, stop_e;

    assign start_e = start & ~start_d;
    assign stop_e  = stop & ~stop_d;
    assign accept  = (st == W_IDLE) && start_e;
    assign osc_en  = (st == W_RUN);
    assign capture = (st == W_SETTLE);

    always_ff @(posedge clk) begin
        if (rst) begin
            st      <= W_IDLE;
            start_d <= 1'b0;
            stop_d  <= 1'b0;
        end else begin
            start_d <= start;
            stop_d  <= stop;
            case (st)
                W_IDLE:   if (start_e) st <= W_RUN;
                W_RUN:    if (stop_e)  st <= W_SETTLE;
                W_SETTLE: st <= W_IDLE;
                default:  st <= W_IDLE;
            endcase
        end
    end

    // R1: a stop edge inside the window closes it at the next edge
    p_stop_closes_r1: assert property (@(posedge clk) disable iff (rst)
        (osc_en && stop_e) |=> !osc_en);
    // R8: a stop with no open window never opens one
    p_idle_stop_r8: assert property (@(posedge clk) disable iff (rst)
        (!osc_en && !start_e) |=> !osc_en);
    // R5: capture strobe only follows a closing window
    p_capture_after_close_r5: assert property (@(posedge clk) disable iff (rst)
        (osc_en && stop_e) |=> capture);
endmodule

// File: rtl/tdc_coarse.sv
module tdc_coarse #(
    parameter int unsigned CW = 10
) (
    input  logic          clk,
    input  logic          clr,
    input  logic          en,
    input  logic          ph_last,
    output logic [CW-1:0] cnt,
    output logic          ovf
);
    localparam logic [CW-1:0] CMAX = {CW{1'b1}};

    logic prev;
    logic tick;

    assign tick = en && ph_last && !prev;

    always_ff @(posedge clk) begin
        prev <= ph_last;
        if (clr) begin
            cnt <= '0;
            ovf <= 1'b0;
        end else if (tick) begin
            if (cnt == CMAX) ovf <= 1'b1;
            else             cnt <= cnt + 1'b1;
        end
    end

    // R3: saturated count stays at the top
    p_sat_hold_r3: assert property (@(posedge clk) disable iff (clr)
        (cnt == CMAX) |=> (cnt == CMAX));
    // R3: overflow is sticky until the next clear
    p_ovf_sticky_r3: assert property (@(posedge clk) disable iff (clr)
        ovf |=> ovf);
    // R2: nothing is counted outside the window
    p_no_count_idle_r2: assert property (@(posedge clk) disable iff (clr)
        !en |=> $stable(cnt));
endmodule

// File: rtl/tdc_fine.sv
module tdc_fine
    import tdc_pkg::*;
#(
    parameter int unsigned NPH = 63,
    parameter int unsigned FW  = 6
) (
    input  logic [NPH-1:0] therm,
    output logic [FW-1:0]  fine
);
    logic [254:0] wide;

    always_comb begin
        wide           = '0;
        wide[NPH-1:0]  = therm;
        fine           = FW'(lead_ones(wide, NPH));
        // R4: a zero at the bottom tap always yields a zero fine value
        if (!therm[0]) a_zero_base_r4: assert (fine == '0);
    end
endmodule

// File: rtl/tdc_capture.sv
module tdc_capture
    import tdc_pkg::*;
#(
    parameter int unsigned CODE_W = 16,
    parameter int unsigned FINE_W = 6,
    parameter int unsigned NPH    = (1 << FINE_W) - 1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  logic              stop,
    input  logic              load,
    input  logic [NPH-1:0]    phase,
    output logic              osc_en,
    output logic [CODE_W-1:0] code,
    output logic              code_ovf
);
    localparam int unsigned CW = CODE_W - FINE_W;

    logic              accept, capture;
    logic [CW-1:0]     cnt;
    logic              ovf;
    logic [FINE_W-1:0] fine;
    logic [CODE_W-1:0] meas;
    logic              meas_ovf;
    logic              load_d;
    logic              load_e;

    tdc_window u_win (
        .clk     (clk),
        .rst     (rst),
        .start   (start),
        .stop    (stop),
        .osc_en  (osc_en),
        .accept  (accept),
        .capture (capture)
    );

    tdc_coarse #(.CW(CW)) u_coarse (
        .clk     (clk),
        .clr     (rst | accept),
        .en      (osc_en),
        .ph_last (phase[NPH-1]),
        .cnt     (cnt),
        .ovf     (ovf)
    );

    tdc_fine #(.NPH(NPH), .FW(FINE_W)) u_fine (
        .therm (phase),
        .fine  (fine)
    );

    assign load_e = load & ~load_d;

    always_ff @(posedge clk) begin
        if (rst) begin
            meas     <= '0;
            meas_ovf <= 1'b0;
            code     <= '0;
            code_ovf <= 1'b0;
            load_d   <= 1'b0;
        end else begin
            load_d <= load;
            if (capture) begin
                meas     <= {cnt, fine};
                meas_ovf <= ovf;
            end
            if (load_e) begin
                code     <= meas;
                code_ovf <= meas_ovf;
            end
        end
    end

    // R6: a load edge publishes the captured word
    p_load_copy_r6: assert property (@(posedge clk) disable iff (rst)
        load_e |=> (code == $past(meas)));
    // R6: without a load edge the output holds
    p_hold_r6: assert property (@(posedge clk) disable iff (rst)
        !load_e |=> $stable(code) && $stable(code_ovf));
    // R7: reset clears the pixel outputs
    p_reset_clear_r7: assert property (@(posedge clk)
        rst |=> (code == '0) && !code_ovf && !osc_en);
endmodule

// File: tb/tdc_capture_tb.sv
module tdc_capture_tb;
    localparam int CODE_W = 16;
    localparam int FINE_W = 6;
    localparam int NPH    = 63;
    localparam int CMAX   = 1023;

    typedef struct {
        logic [CODE_W-1:0] code;
        logic              ovf;
        string             tag;
    } exp_t;

    logic              clk = 1'b0;
    logic              rst, start, stop, load;
    logic [NPH-1:0]    phase;
    logic              osc_en;
    logic [CODE_W-1:0] code;
    logic              code_ovf;

    int   total = 0;
    int   bad   = 0;
    exp_t q[$];
    logic load_seen = 1'b0;

    always #5 clk = ~clk;

    tdc_capture u_dut (
        .clk(clk), .rst(rst), .start(start), .stop(stop), .load(load),
        .phase(phase), .osc_en(osc_en), .code(code), .code_ovf(code_ovf)
    );

    always @(posedge clk) load_seen <= load;

    // monitor: compares each published word against the queue
    always @(negedge clk) begin
        if (load_seen && q.size() > 0) begin
            exp_t e;
            e = q.pop_front();
            total++;
            if (code !== e.code || code_ovf !== e.ovf) begin
                bad++;
                $display("FAIL %s: code=%0d ovf=%0b expected code=%0d ovf=%0b",
                         e.tag, code, code_ovf, e.code, e.ovf);
            end
        end
    end

    task automatic chk1(input string tag, input logic act, input logic exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s: got %0b expected %0b", tag, act, exp);
        end
    endtask

    task automatic do_load(input logic [CODE_W-1:0] ec, input logic eo, input string tag);
        exp_t e;
        e.code = ec; e.ovf = eo; e.tag = tag;
        @(negedge clk);
        q.push_back(e);
        load = 1'b1;
        @(negedge clk);
        load = 1'b0;
        @(negedge clk);
    endtask

    task automatic edges(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk); phase[NPH-1] = 1'b1;
            @(negedge clk); phase[NPH-1] = 1'b0;
        end
    endtask

    // one window: n edges, thermometer at stop, optional start mid-window
    task automatic measure(input int n, input logic [NPH-2:0] th,
                           input bit restart, input string tag);
        phase = '0;
        @(negedge clk); start = 1'b1;
        @(negedge clk); start = 1'b0;
        chk1({tag, " R1 open"}, osc_en, 1'b1);
        if (restart) begin
            edges(n / 2);
            @(negedge clk); start = 1'b1;
            @(negedge clk); start = 1'b0;
            edges(n - n / 2);
        end else begin
            edges(n);
        end
        @(negedge clk); phase = {1'b0, th}; stop = 1'b1;
        @(negedge clk); stop = 1'b0;
        chk1({tag, " R1 close"}, osc_en, 1'b0);
        @(negedge clk);
    endtask

    function automatic logic [CODE_W-1:0] expect_code(input int n, input int f);
        int c;
        c = (n > CMAX) ? CMAX : n;
        return CODE_W'(c * (1 << FINE_W) + f);
    endfunction

    initial begin
        #(10 * 200000);
        bad++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        rst = 1'b1; start = 1'b0; stop = 1'b0; load = 1'b0; phase = '0;
        repeat (3) @(negedge clk);
        chk1("R7 reset osc_en", osc_en, 1'b0);
        chk1("R7 reset code", code == '0, 1'b1);
        rst = 1'b0;

        // R2 R5: plain counts with several fine values
        measure(5, 62'h7, 1'b0, "R5 n5 f3");
        do_load(expect_code(5, 3), 1'b0, "R5 n5 f3");
        measure(0, 62'h0, 1'b0, "R2 n0 f0");
        do_load(expect_code(0, 0), 1'b0, "R2 n0 f0");
        measure(17, {62{1'b1}}, 1'b0, "R4 n17 f62");
        do_load(expect_code(17, 62), 1'b0, "R4 n17 f62");

        // R4: bubble above first zero ignored (bits 0,1 set, 2 clear, 3 set)
        measure(2, 62'hB, 1'b0, "R4 bubble");
        do_load(expect_code(2, 2), 1'b0, "R4 bubble");
        measure(1, 62'h3FF0F, 1'b0, "R4 bubble2");
        do_load(expect_code(1, 4), 1'b0, "R4 bubble2");

        // R9: start inside the window does not clear the count
        measure(8, 62'h1, 1'b1, "R9 restart");
        do_load(expect_code(8, 1), 1'b0, "R9 restart");

        // R2: edges after the window closes are not counted
        measure(4, 62'h0, 1'b0, "R2 post");
        edges(3);
        do_load(expect_code(4, 0), 1'b0, "R2 post");

        // R8: stray stop while idle, then a second stop, leave word intact
        @(negedge clk); stop = 1'b1;
        @(negedge clk); stop = 1'b0;
        chk1("R8 idle stop osc_en", osc_en, 1'b0);
        @(negedge clk);
        do_load(expect_code(4, 0), 1'b0, "R8 idle stop");
        measure(6, 62'h1F, 1'b0, "R8 double");
        @(negedge clk); stop = 1'b1;
        @(negedge clk); stop = 1'b0;
        @(negedge clk);
        do_load(expect_code(6, 5), 1'b0, "R8 double");

        // R6: no load edge -> output holds across a new capture
        measure(9, 62'h0, 1'b0, "R6 hold");
        @(negedge clk);
        total++;
        if (code !== expect_code(6, 5)) begin
            bad++;
            $display("FAIL R6 hold: got %0d expected %0d", code, expect_code(6, 5));
        end
        do_load(expect_code(9, 0), 1'b0, "R6 latch");

        // R3: boundary at saturation
        measure(CMAX, 62'h3, 1'b0, "R3 at max");
        do_load(expect_code(CMAX, 2), 1'b0, "R3 at max");
        measure(CMAX + 1, 62'h3, 1'b0, "R3 over");
        do_load(expect_code(CMAX + 1, 2), 1'b1, "R3 over");
        measure(CMAX + 6, 62'h0, 1'b0, "R3 over6");
        do_load(expect_code(CMAX + 6, 0), 1'b1, "R3 over6");

        // R7: reset in the middle of a window
        @(negedge clk); start = 1'b1;
        @(negedge clk); start = 1'b0;
        edges(3);
        @(negedge clk); rst = 1'b1;
        @(negedge clk); rst = 1'b0;
        chk1("R7 mid osc_en", osc_en, 1'b0);
        chk1("R7 mid code", code == '0, 1'b1);
        chk1("R7 mid ovf", code_ovf, 1'b0);
        @(negedge clk); stop = 1'b1;
        @(negedge clk); stop = 1'b0;
        @(negedge clk);
        do_load('0, 1'b0, "R7 after reset");

        repeat (3) @(negedge clk);
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule